// File: doc/BRIEF.md
# Indirect register bridge

This block is a bus slave that opens a wide internal register space through a narrow window. Each of its two channels has three host-visible registers: a pointer, a data port and a control word. The host writes the pointer to pick an internal register. It then moves data through the data port. Each channel drives its own internal store. Channel A keeps 32-bit words and channel B keeps 8-bit values. For this block, each store is a small test memory.

The pointer is guarded. A channel accepts a pointer only after the same low-16-bit value has been written to the pointer register twice in a row. Until then the data port is closed. Reads go through a one-deep fetch register. Every armed data read returns whatever the previous armed read fetched, and it starts a new fetch at the current pointer. A host therefore reads the data port twice and keeps the second result. A write needs only one data-port write.

A bit in each control word chooses how closed-port accesses end. When the bit is set, they end in a bus error. When it is clear, they complete quietly: reads return zero and writes are dropped. The host interface takes one request per cycle and answers each request with a registered response one cycle later.

Top module: `idx_reg_bridge`

## Requirements
- R1: Every cycle with `bus_req` high is answered by `bus_ack` high in the next cycle, together with that request's `bus_rdata` and `bus_err`. A cycle without a request gives `bus_ack` low in the next cycle. Write responses carry zero read data.
- R2: Register map by `bus_off`: channel A pointer 0x00, data 0x04, control 0x08; channel B pointer 0x10, data 0x14, control 0x18. Bits [1:0] of `bus_off` are ignored. Offsets 0x0C and 0x1C read zero, ignore writes and never raise an error.
- R3: A pointer write keeps only bits [15:0] of `bus_wdata`, and a pointer read returns the last kept value, zero-extended. The channel is armed when its two most recent pointer writes carry equal 16-bit values. A pointer write that differs from the one before it leaves the channel unarmed.
- R4: An armed data read returns the value fetched by that channel's previous armed data read (zero after reset). It also fetches the internal register at the current pointer, so the second of two back-to-back reads returns that register's contents.
- R5: An armed data write stores `bus_wdata` in the internal register selected by the low IDX_W bits of the pointer (6 bits by default, so pointer 0x0043 selects the same word as 0x0003). A single write is enough.
- R6: Only bit 15 of a control register can be stored. A control read returns that bit in position 15 with all other bits zero.
- R7: A data access on an unarmed channel never changes the store or the fetched value. With control bit 15 set, the access responds with `bus_err` high and zero data. With bit 15 clear, it responds without error and with zero data.
- R8: Channel B stores only bits [7:0] of written data, and its data reads are zero-extended. Channel A stores all 32 bits.
- R9: The channels are independent. Arming, control bit and fetched value of one channel are not changed by accesses to the other.
- R10: Synchronous reset leaves both channels unarmed with control bit 15 clear and fetched value zero. `bus_ack`, `bus_err` and `bus_rdata` are all zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 5 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Registered response valid |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered error response |

## Verification
Several behaviours are checked by assertions on every cycle:
- the one-cycle response timing and the absence of unrequested acknowledges;
- an error only appearing on an acknowledge;
- arming only after a matching pair of pointer writes, and disarming after a mismatch;
- the fetch register holding still between armed reads;
- channel B never returning bits above bit 7.

The remaining behaviours depend on stored state, so only the bench's scenarios can show them:
- the stale first read and valid second read;
- dropped writes while unarmed;
- index aliasing of wide pointers;
- the independence of the two channels;
- the return to the unarmed state after reset.

// File: rtl/idx_bridge_pkg.sv
package idx_bridge_pkg;
  localparam int WORD_W     = 32;
  localparam int PTR_W      = 16;
  localparam int ERR_EN_BIT = 15;
  localparam int CHAN_NUM   = 2;
  localparam int OFF_W      = 5;

  typedef enum logic [1:0] {
    ROLE_PTR  = 2'd0,
    ROLE_DATA = 2'd1,
    ROLE_CTRL = 2'd2,
    ROLE_NONE = 2'd3
  } role_e;
endpackage

// File: rtl/idx_arm.sv
module idx_arm
  import idx_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [PTR_W-1:0] wval,
  output logic             armed,
  output logic [PTR_W-1:0] ptr
);
  logic have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      ptr       <= '0;
      have_prev <= 1'b0;
    end else if (wr) begin
      armed     <= have_prev && (wval == ptr);
      ptr       <= wval;
      have_prev <= 1'b1;
    end
  end

  AST_ARM_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(wr && have_prev && (wval == ptr))); // R3

  AST_DISARM_ON_DIFF: assert property (@(posedge clk) disable iff (rst)
    $past(wr && (wval != ptr)) |-> !armed); // R3
endmodule

// File: rtl/idx_store.sv
module idx_store #(
  parameter int DW    = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[idx];
  end

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(re) |-> $stable(q)); // R4
endmodule

// File: rtl/idx_channel.sv
module idx_channel
  import idx_bridge_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  role_e             role,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic             armed;
  logic [PTR_W-1:0] ptr;
  logic             err_en;
  logic             ptr_wr;
  logic             data_hit;
  logic [DW-1:0]    q;
  logic [WORD_W-1:0] q_ext;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;
  assign ptr_wr   = sel && we && (role == ROLE_PTR);
  assign data_hit = sel && (role == ROLE_DATA);

  idx_arm u_arm (
    .clk   (clk),
    .rst   (rst),
    .wr    (ptr_wr),
    .wval  (wdata[PTR_W-1:0]),
    .armed (armed),
    .ptr   (ptr)
  );

  idx_store #(.DW(DW), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (data_hit && we && armed),
    .re    (data_hit && !we && armed),
    .idx   (ptr[IDX_W-1:0]),
    .wdata (wdata[DW-1:0]),
    .q     (q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      err_en <= 1'b0;
    else if (sel && we && (role == ROLE_CTRL))
      err_en <= wdata[ERR_EN_BIT];
  end

  always_comb begin
    q_ext = '0;
    q_ext[DW-1:0] = q;
  end

  always_comb begin
    rsp_data = '0;
    rsp_err  = 1'b0;
    if (sel) begin
      case (role)
        ROLE_PTR:  if (!we) rsp_data[PTR_W-1:0] = ptr;
        ROLE_DATA: begin
          if (!armed)   rsp_err  = err_en;
          else if (!we) rsp_data = q_ext;
        end
        ROLE_CTRL: if (!we) rsp_data[ERR_EN_BIT] = err_en;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
  import idx_bridge_pkg::*;
#(
  parameter int A_DATA_W = 32,
  parameter int B_DATA_W = 8,
  parameter int IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err
);
  localparam int CH_BIT = OFF_W - 1;

  role_e             role;
  logic [WORD_W-1:0] ch_data [CHAN_NUM];
  logic              ch_err  [CHAN_NUM];
  logic              unused_off;

  assign role       = role_e'(bus_off[3:2]);
  assign unused_off = ^bus_off[1:0];

  for (genvar g = 0; g < CHAN_NUM; g++) begin : g_ch
    localparam int DW = (g == 0) ? A_DATA_W : B_DATA_W;
    idx_channel #(.DW(DW), .IDX_W(IDX_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .sel      (bus_req && (bus_off[CH_BIT] == g[0])),
      .we       (bus_we),
      .role     (role),
      .wdata    (bus_wdata),
      .rsp_data (ch_data[g]),
      .rsp_err  (ch_err[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= bus_req ? ch_data[bus_off[CH_BIT]] : '0;
      bus_err   <= bus_req && ch_err[bus_off[CH_BIT]];
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack); // R1

  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ack); // R1

  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack); // R7

  AST_CHB_NARROW: assert property (@(posedge clk) disable iff (rst)
    $past(bus_req && !bus_we && (bus_off[4:2] == 3'b101))
      |-> (bus_rdata[WORD_W-1:B_DATA_W] == '0)); // R8
endmodule

// File: tb/sim_idx_reg_bridge.sv
`timescale 1ns/1ps
module sim_idx_reg_bridge;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req;
  logic        bus_we;
  logic [4:0]  bus_off;
  logic [31:0] bus_wdata;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_d [$];
  logic        exp_e [$];
  string       exp_t [$];

  logic [31:0] m_d;
  logic        m_e;
  string       m_t;

  always #2 clk = ~clk;

  idx_reg_bridge u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one request per call, back to back
  task automatic op(input logic we, input logic [4:0] off, input logic [31:0] wd,
                    input logic [31:0] ed, input logic ee, input string tag);
    @(negedge clk);
    bus_req   = 1'b1;
    bus_we    = we;
    bus_off   = off;
    bus_wdata = wd;
    exp_d.push_back(ed);
    exp_e.push_back(ee);
    exp_t.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0; bus_off = '0; bus_wdata = '0;
    end
  endtask

  // monitor: pop and compare on each acknowledge
  always @(negedge clk) begin
    if (!rst && bus_ack) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R1 unexpected ack", {bus_err, bus_rdata}, 33'h0);
      end else begin
        m_d = exp_d.pop_front();
        m_e = exp_e.pop_front();
        m_t = exp_t.pop_front();
        chk((bus_rdata === m_d) && (bus_err === m_e), m_t,
            {bus_err, bus_rdata}, {m_e, m_d});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic RD = 1'b0;
  localparam logic WR = 1'b1;

  initial begin
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_off = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    chk(bus_ack === 1'b0 && bus_err === 1'b0 && bus_rdata === 32'h0,
        "R10 outputs in reset", {bus_err, bus_rdata}, 33'h0);
    rst = 1'b0;

    op(RD, 5'h08, 0, 32'h0, 0, "R10 ctrl A reset zero");
    op(RD, 5'h04, 0, 32'h0, 0, "R7 unarmed read quiet");
    op(WR, 5'h04, 32'hDEAD, 32'h0, 0, "R7 unarmed write quiet");
    op(WR, 5'h00, 5, 32'h0, 0, "R3 first ptr write");
    op(WR, 5'h00, 5, 32'h0, 0, "R3 second ptr write");
    op(RD, 5'h04, 0, 32'h0, 0, "R4 first read returns reset fetch");
    op(RD, 5'h04, 0, 32'h0, 0, "R7 dropped write left word 5 zero");
    // mismatch leaves channel unarmed
    op(WR, 5'h00, 3, 32'h0, 0, "R3 ptr 3");
    op(WR, 5'h00, 4, 32'h0, 0, "R3 ptr 4 differs");
    op(WR, 5'h08, 32'hFFFF_FFFF, 32'h0, 0, "R6 ctrl write");
    op(RD, 5'h08, 0, 32'h0000_8000, 0, "R6 only bit 15 kept");
    op(RD, 5'h04, 0, 32'h0, 1, "R7 unarmed read error");
    op(WR, 5'h04, 32'h77, 32'h0, 1, "R7 unarmed write error");
    op(RD, 5'h00, 0, 32'h0000_0004, 0, "R3 ptr readback");
    // arm with differing upper bits
    op(WR, 5'h00, 32'h1234_0003, 32'h0, 0, "R3 ptr 3 upper junk");
    op(WR, 5'h00, 32'hABCD_0003, 32'h0, 0, "R3 ptr 3 again");
    op(RD, 5'h00, 0, 32'h0000_0003, 0, "R3 only low 16 kept");
    op(WR, 5'h04, 32'hCAFE_F00D, 32'h0, 0, "R5 single write");
    op(RD, 5'h04, 0, 32'h0, 0, "R4 first read stale");
    op(RD, 5'h04, 0, 32'hCAFE_F00D, 0, "R4 second read valid R5");
    op(WR, 5'h00, 7, 32'h0, 0, "R3 ptr 7");
    op(WR, 5'h00, 7, 32'h0, 0, "R3 ptr 7 again");
    op(WR, 5'h04, 32'h1111_1111, 32'h0, 0, "R5 write word 7");
    op(RD, 5'h04, 0, 32'hCAFE_F00D, 0, "R4 stale from word 3");
    op(RD, 5'h04, 0, 32'h1111_1111, 0, "R4 word 7 valid");
    op(WR, 5'h00, 4, 32'h0, 0, "R3 ptr 4");
    op(WR, 5'h00, 4, 32'h0, 0, "R3 ptr 4 again");
    op(RD, 5'h04, 0, 32'h1111_1111, 0, "R4 stale from word 7");
    op(RD, 5'h04, 0, 32'h0, 0, "R7 error write not stored");
    op(WR, 5'h00, 32'h43, 32'h0, 0, "R5 ptr 0x43");
    op(WR, 5'h00, 32'h43, 32'h0, 0, "R5 ptr 0x43 again");
    op(RD, 5'h04, 0, 32'h0, 0, "R5 alias first read");
    op(RD, 5'h04, 0, 32'hCAFE_F00D, 0, "R5 0x43 aliases word 3");
    op(WR, 5'h00, 9, 32'h0, 0, "R3 third write differs");
    op(RD, 5'h04, 0, 32'h0, 1, "R3 disarmed after mismatch");
    // channel B
    op(RD, 5'h18, 0, 32'h0, 0, "R9 ctrl B untouched");
    op(RD, 5'h14, 0, 32'h0, 0, "R9 B unarmed quiet");
    op(WR, 5'h10, 2, 32'h0, 0, "R8 B ptr 2");
    op(WR, 5'h10, 2, 32'h0, 0, "R8 B ptr 2 again");
    op(WR, 5'h14, 32'hABCD_1234, 32'h0, 0, "R8 B write");
    op(RD, 5'h14, 0, 32'h0, 0, "R9 B fetch independent of A");
    op(RD, 5'h14, 0, 32'h0000_0034, 0, "R8 B keeps 8 bits");
    op(RD, 5'h04, 0, 32'h0, 1, "R9 A still unarmed with error");
    // map corners
    op(RD, 5'h0C, 0, 32'h0, 0, "R2 0x0C reads zero no error");
    op(WR, 5'h1C, 32'hFFFF, 32'h0, 0, "R2 0x1C write ignored");
    op(RD, 5'h1C, 0, 32'h0, 0, "R2 0x1C still zero");
    op(RD, 5'h15, 0, 32'h0000_0034, 0, "R2 low offset bits ignored");
    op(RD, 5'h16, 0, 32'h0000_0034, 0, "R2 low offset bits ignored again");
    op(WR, 5'h0B, 0, 32'h0, 0, "R6 clear ctrl A");
    op(RD, 5'h04, 0, 32'h0, 0, "R7 quiet with bit 15 clear");
    idle(3);
    chk(bus_ack === 1'b0, "R1 no ack while idle", {32'h0, bus_ack}, 33'h0);
    // arm A, then reset
    op(WR, 5'h00, 3, 32'h0, 0, "R10 pre-reset ptr");
    op(WR, 5'h00, 3, 32'h0, 0, "R10 pre-reset ptr again");
    idle(3);
    rst = 1'b1;
    idle(3);
    chk(bus_ack === 1'b0 && bus_rdata === 32'h0, "R10 outputs in second reset",
        {bus_err, bus_rdata}, 33'h0);
    rst = 1'b0;
    op(RD, 5'h08, 0, 32'h0, 0, "R10 ctrl cleared");
    op(WR, 5'h08, 32'h8000, 32'h0, 0, "R10 set ctrl");
    op(RD, 5'h04, 0, 32'h0, 1, "R10 disarmed after reset");
    idle(4);
    chk(exp_d.size() == 0, "R1 all requests answered", 33'(exp_d.size()), 33'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule